// File: doc/BRIEF.md
# Differential Address Trace Packet Encoder

This block turns one address-reporting event of an instruction-trace unit into a compact byte stream. For each accepted request it forms an address field: either the distance from the address it last reported, or, in full-address mode, the absolute address. The always-zero low bits of the instruction address are dropped first. It places a fixed two-bit format code below the field and three event flags above it. Each flag is stored relative to the field's sign bit. The block then trims every redundant upper bit of the complete payload. A receiver restores the dropped bits by sign-extending the last byte it receives.

Requests arrive on a valid/ready port. `in_ready` is high only while no packet is being emitted. A request is taken in any cycle where `in_valid` and `in_ready` are both high, and the request fields must be held steady until then. Payload bytes leave on a valid/ready port, least significant byte first. A byte moves on each cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the current byte, its last-byte marker and the length are all held. `out_len` gives the packet length in bytes for the whole packet.

Top module: `tpk_diff_encoder`

## Requirements
- R1: The address field is FIELD_W = ADDR_W - LSB_W bits wide and is taken from address bits [ADDR_W-1:LSB_W]. In differential mode (`in_full_mode`=0) it is the current field minus the field of the last reported address, modulo 2^FIELD_W. In full mode it is the current field itself. Address bits below LSB_W have no effect on the output.
- R2: The last-reported address resets to zero and is replaced by `in_addr` on every accepted request, in either mode, and at no other time.
- R3: The payload is PAY_W = FIELD_W + 5 bits. Bits [1:0] hold the format code 2 (bit 1 = 1, bit 0 = 0). Bits [FIELD_W+1:2] hold the address field. Bit FIELD_W+2 is notify, bit FIELD_W+3 is updiscon and bit FIELD_W+4 is irreport. Each flag bit is stored as the field's most significant bit XOR the flag.
- R4: `out_len` is the smallest n ≥ 1 such that sign-extending payload bits [8n-1:0] reproduces the full payload. It never exceeds NBYTES = ceil(PAY_W/8).
- R5: Byte k of a packet (k = 0 first) is bits [8k+7:8k] of the payload sign-extended to 8·NBYTES bits. `out_last` is high exactly on byte `out_len`-1.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_len` keep their values.
- R7: `in_ready` is high only when no packet is in flight. After an accepted request, `out_valid` is high in the next cycle. After the last byte is transferred, `in_ready` is high in the next cycle.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: With ADDR_W=32 and LSB_W=1, all flags clear and differential mode, a report of 0x8000010c following one of 0x80000104 is the single byte 0x12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Encoder can take a request |
| in_addr | input | ADDR_W | Current instruction address |
| in_full_mode | input | 1 | 1 = absolute address field, 0 = differential |
| in_notify | input | 1 | Notify flag |
| in_updiscon | input | 1 | Updiscon flag |
| in_irreport | input | 1 | Irreport flag |
| out_valid | output | 1 | Payload byte present |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Payload byte, least significant first |
| out_last | output | 1 | Final byte of the packet |
| out_len | output | LEN_W | Packet length in bytes |

## Verification
The bench builds two small instances with an 8-bit address: one with LSB_W=1 (a 12-bit payload in at most two bytes) and one with LSB_W=2 (an 11-bit payload). For each, it sweeps all 256 addresses, both modes and all eight flag combinations, under a repeating stall pattern on `out_ready`. This covers every delta sign, wrap-around, odd low bits, flag/sign disagreement, and both one-byte and two-byte lengths. A third instance with the 32-bit default configuration checks the one-byte worked example and a few long, full-mode packets that use all five bytes.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  localparam logic [1:0] FMT_ADDR = 2'd2;
  typedef enum logic {ST_IDLE, ST_SEND} tpk_state_e;
endpackage

// File: rtl/tpk_addr_field.sv
module tpk_addr_field #(
  parameter int ADDR_W = 32,
  parameter int LSB_W  = 1,
  localparam int FIELD_W = ADDR_W - LSB_W
) (
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [ADDR_W-1:0]  last_addr,
  input  logic               full_mode,
  output logic [FIELD_W-1:0] field
);
  logic [FIELD_W-1:0] cur_f, last_f;
  assign cur_f  = cur_addr[ADDR_W-1:LSB_W];
  assign last_f = last_addr[ADDR_W-1:LSB_W];

  always_comb begin
    if (full_mode) field = cur_f;
    else           field = cur_f - last_f;
  end
endmodule

// File: rtl/tpk_payload_pack.sv
module tpk_payload_pack #(
  parameter int FIELD_W = 31,
  parameter int NBYTES  = 5,
  parameter int LEN_W   = 3,
  localparam int PAY_W  = FIELD_W + 5,
  localparam int PADW   = NBYTES * 8
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               notify,
  input  logic               updiscon,
  input  logic               irreport,
  output logic [PADW-1:0]    payload,
  output logic [LEN_W-1:0]   len
);
  import tpk_pkg::*;

  logic             sgn;
  logic [PAY_W-1:0] raw;

  assign sgn = field[FIELD_W-1];
  assign raw = {irreport ^ sgn, updiscon ^ sgn, notify ^ sgn, field, FMT_ADDR};

  generate
    if (PADW > PAY_W) begin : g_pad
      assign payload = {{(PADW-PAY_W){raw[PAY_W-1]}}, raw};
    end else begin : g_nopad
      assign payload = raw;
    end
  endgenerate

  // Highest bit that differs from the payload sign bit sets the length.
  always_comb begin
    int hi;
    hi = -1;
    for (int b = 0; b < PAY_W - 1; b++) begin
      if (raw[b] != raw[PAY_W-1]) hi = b;
    end
    if (hi < 0) len = LEN_W'(1);
    else        len = LEN_W'((hi + 9) / 8);
  end
endmodule

// File: rtl/tpk_byte_streamer.sv
module tpk_byte_streamer #(
  parameter int NBYTES = 5,
  parameter int LEN_W  = 3,
  localparam int PADW  = NBYTES * 8,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [PADW-1:0]  load_pay,
  input  logic [LEN_W-1:0] load_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len
);
  import tpk_pkg::*;

  tpk_state_e       st;
  logic [PADW-1:0]  pay_r;
  logic [LEN_W-1:0] len_r;
  logic [IDX_W-1:0] idx;

  assign load_ready = (st == ST_IDLE);
  assign out_valid  = (st == ST_SEND);
  assign out_len    = len_r;
  assign out_last   = (int'(idx) + 1 == int'(len_r));

  always_comb begin
    out_data = pay_r[7:0];
    for (int k = 0; k < NBYTES; k++) begin
      if (int'(idx) == k) out_data = pay_r[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      pay_r <= '0;
      len_r <= '0;
      idx   <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (load_valid) begin
            pay_r <= load_pay;
            len_r <= load_len;
            idx   <= '0;
            st    <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            if (out_last) st <= ST_IDLE;
            else          idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tpk_diff_encoder.sv
module tpk_diff_encoder #(
  parameter int ADDR_W = 32,
  parameter int LSB_W  = 1,
  localparam int FIELD_W = ADDR_W - LSB_W,
  localparam int PAY_W   = FIELD_W + 5,
  localparam int NBYTES  = (PAY_W + 7) / 8,
  localparam int LEN_W   = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_full_mode,
  input  logic              in_notify,
  input  logic              in_updiscon,
  input  logic              in_irreport,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic [LEN_W-1:0]  out_len
);
  logic [ADDR_W-1:0]   last_addr;
  logic [FIELD_W-1:0]  field;
  logic [NBYTES*8-1:0] payload;
  logic [LEN_W-1:0]    len;
  logic                accept;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_addr <= '0;
    else if (accept) last_addr <= in_addr;
  end

  tpk_addr_field #(.ADDR_W(ADDR_W), .LSB_W(LSB_W)) u_field (
    .cur_addr (in_addr),
    .last_addr(last_addr),
    .full_mode(in_full_mode),
    .field    (field)
  );

  tpk_payload_pack #(.FIELD_W(FIELD_W), .NBYTES(NBYTES), .LEN_W(LEN_W)) u_pack (
    .field   (field),
    .notify  (in_notify),
    .updiscon(in_updiscon),
    .irreport(in_irreport),
    .payload (payload),
    .len     (len)
  );

  tpk_byte_streamer #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_stream (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_valid(in_valid),
    .load_ready(in_ready),
    .load_pay  (payload),
    .load_len  (len),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_len   (out_len)
  );
endmodule

// File: rtl/tpk_diff_encoder_chk.sv
module tpk_diff_encoder_chk #(
  parameter int NBYTES = 5,
  parameter int LEN_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic [LEN_W-1:0] out_len
);
  logic [LEN_W-1:0] sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sent <= '0;
    else if (out_valid && out_ready) sent <= out_last ? '0 : sent + 1'b1;
  end

  assert_len_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_len) >= 1 && int'(out_len) <= NBYTES));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last) && $stable(out_len)));

  assert_accept_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && !in_ready));

  assert_done_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> in_ready);

  assert_last_position_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> (int'(sent) + 1 == int'(out_len)));

  assert_not_last_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> (int'(sent) + 1 < int'(out_len)));
endmodule

bind tpk_diff_encoder tpk_diff_encoder_chk #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last),
  .out_len  (out_len)
);

// File: tb/tpk_diff_encoder_tb.sv
`timescale 1ns/1ps
module tpk_diff_encoder_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic [31:0] a;
  logic        fm, nf, ud, irq;
  logic [2:0]  iv;
  logic        ordy;
  logic        rdy [3];
  logic        ov  [3];
  logic [7:0]  od  [3];
  logic        ol  [3];
  logic [3:0]  olen[3];
  logic [1:0]  len0, len1;
  logic [2:0]  len2;
  logic        r0, r1, r2, v0, v1, v2, l0, l1, l2;
  logic [7:0]  d0, d1, d2;

  int errors = 0, checks = 0, pc = 0;
  logic [31:0] prev_m[3];
  bit done = 0;

  tpk_diff_encoder #(.ADDR_W(8), .LSB_W(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(r0), .in_addr(a[7:0]),
    .in_full_mode(fm), .in_notify(nf), .in_updiscon(ud), .in_irreport(irq),
    .out_valid(v0), .out_ready(ordy), .out_data(d0), .out_last(l0), .out_len(len0));
  tpk_diff_encoder #(.ADDR_W(8), .LSB_W(2)) u_dut_l2 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(r1), .in_addr(a[7:0]),
    .in_full_mode(fm), .in_notify(nf), .in_updiscon(ud), .in_irreport(irq),
    .out_valid(v1), .out_ready(ordy), .out_data(d1), .out_last(l1), .out_len(len1));
  tpk_diff_encoder #(.ADDR_W(32), .LSB_W(1)) u_dut_w32 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv[2]), .in_ready(r2), .in_addr(a),
    .in_full_mode(fm), .in_notify(nf), .in_updiscon(ud), .in_irreport(irq),
    .out_valid(v2), .out_ready(ordy), .out_data(d2), .out_last(l2), .out_len(len2));

  always_comb begin
    rdy[0] = r0; rdy[1] = r1; rdy[2] = r2;
    ov[0] = v0;  ov[1] = v1;  ov[2] = v2;
    od[0] = d0;  od[1] = d1;  od[2] = d2;
    ol[0] = l0;  ol[1] = l1;  ol[2] = l2;
    olen[0] = {2'b0, len0}; olen[1] = {2'b0, len1}; olen[2] = {1'b0, len2};
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
    end
  endtask

  // Arithmetic model of the requirements R1, R3, R4, R5.
  task automatic model(input int aw, input int lsb, input logic [31:0] addr, input logic [31:0] prv,
                       input bit full, input bit n, input bit u, input bit i,
                       output logic [63:0] pay, output int len);
    int fw, pw, h;
    logic [63:0] cf, pf, fld, msk;
    bit s, m;
    fw  = aw - lsb;
    pw  = fw + 5;
    msk = (64'd1 << aw) - 1;
    cf  = ({32'd0, addr} & msk) >> lsb;
    pf  = ({32'd0, prv} & msk) >> lsb;
    fld = (full ? cf : cf - pf) & ((64'd1 << fw) - 1);
    s   = fld[fw-1];
    pay = 64'd2 | (fld << 2) | (64'(n ^ s) << (fw + 2)) | (64'(u ^ s) << (fw + 3)) | (64'(i ^ s) << (fw + 4));
    m   = pay[pw-1];
    if (m) pay = pay | ~((64'd1 << pw) - 1);
    h = -1;
    for (int b = 0; b < pw - 1; b++) if (pay[b] != m) h = b;
    len = (h < 0) ? 1 : (h + 9) / 8;
  endtask

  task automatic run_pkt(input int d, input int aw, input int lsb, input logic [31:0] addr,
                         input bit full, input bit n, input bit u, input bit i,
                         output logic [7:0] first, output int glen);
    logic [63:0] pay;
    int elen, k, guard;
    model(aw, lsb, addr, prev_m[d], full, n, u, i, pay, elen);
    @(negedge clk);
    a = addr; fm = full; nf = n; ud = u; irq = i;
    iv[d] = 1'b1;
    chk(rdy[d] === 1'b1, "R7 in_ready idle", 64'(rdy[d]), 64'd1);
    @(negedge clk);
    iv[d] = 1'b0;
    prev_m[d] = addr;
    first = od[d];
    glen = int'(olen[d]);
    chk(ov[d] === 1'b1, "R7 out_valid after accept", 64'(ov[d]), 64'd1);
    chk(int'(olen[d]) == elen, "R4 out_len", 64'(olen[d]), 64'(elen));
    k = 0; guard = 0;
    while (k < elen && guard < 64) begin
      ordy = (pc % 4) != 3;
      pc++; guard++;
      chk(ov[d] === 1'b1 && od[d] === pay[8*k +: 8], ordy ? "R5 byte" : "R6 stalled byte",
          64'(od[d]), pay[8*k +: 8]);
      chk(ol[d] === (k == elen - 1), "R5 out_last", 64'(ol[d]), 64'(k == elen - 1));
      @(negedge clk);
      if (ordy) k++;
    end
    ordy = 1'b0;
    chk(ov[d] === 1'b0 && rdy[d] === 1'b1, "R7 idle after last", {ov[d], rdy[d]}, 64'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] fb;
    int gl;
    rst_n = 1'b0; iv = '0; ordy = 1'b0; a = '0; fm = 0; nf = 0; ud = 0; irq = 0;
    for (int d = 0; d < 3; d++) prev_m[d] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 3; d++)
      chk(ov[d] === 1'b0 && rdy[d] === 1'b1, "R8 reset state", {ov[d], rdy[d]}, 64'b01);

    // R9 worked example; the first packet also checks R2 reset value (prev = 0).
    run_pkt(2, 32, 1, 32'h80000104, 0, 0, 0, 0, fb, gl);
    run_pkt(2, 32, 1, 32'h8000010c, 0, 0, 0, 0, fb, gl);
    chk(fb === 8'h12 && gl == 1, "R9 example byte/len", {fb, 8'(gl)}, {8'h12, 8'd1});
    run_pkt(2, 32, 1, 32'h12345678, 1, 1, 0, 1, fb, gl);
    run_pkt(2, 32, 1, 32'h40000001, 1, 0, 1, 0, fb, gl);
    run_pkt(2, 32, 1, 32'h3ffffff0, 0, 1, 1, 1, fb, gl);

    // Sweeps covering R1 (odd low bits, wrap), R2 (prev update in both modes), R3, R4, R5, R6.
    for (int d = 0; d < 2; d++) begin
      for (int fl = 0; fl < 16; fl++) begin
        for (int ad = 0; ad < 256; ad++) begin
          run_pkt(d, 8, d + 1, 32'((ad * 37 + fl * 11) & 8'hff), fl[3], fl[0], fl[1], fl[2], fb, gl);
        end
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule